// File: doc/BRIEF.md
# Seconds Counter With Alarm Compare

This block keeps wall-clock time in a low-power clock domain. Time is one 47-bit value. The low 15 bits are a sub-second fraction and the high 32 bits are whole seconds. The value advances by one on each clock of the slow domain. It does so only after software has enabled counting and has written the seconds half at least once since reset. Until both conditions hold, the time stays frozen.

Software loads the two time halves, the two alarm halves and a control word through write strobes that are already synchronized to this clock. All of them share one data bus. The block compares the full 47-bit time with the alarm after every increment. On a match it raises a sticky alarm flag, which stays set until software writes a one to clear it.

A status write also clears a power-up "not valid" indication and a security-violation indication. Both are cleared together, and only when both clear bits are written as ones. Writing all ones to the alarm seconds turns the alarm off.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset: seconds and fraction are 0, alarm seconds are all ones, alarm fraction is 0, counting is disabled, the alarm flag is 0, nonValid is 1 and violation is 0.
- R2: When counting is enabled and the seconds half has been written since reset, the 47-bit time {seconds, fraction} rises by exactly one on every clock that carries no time write.
- R3: The fraction wraps from 32767 to 0 and carries one into the seconds. The seconds wrap from all ones to 0.
- R4: The time holds its value while counting is disabled. It also holds, even with counting enabled, until the seconds half has been written once after reset. Writing the value 0 is enough to start it.
- R5: A seconds write loads wrData[31:0] and a fraction write loads wrData[14:0]; no increment happens in a cycle that carries either write. Alarm writes load the alarm seconds from wrData[31:0] and the alarm fraction from wrData[14:0].
- R6: A control write sets the count enable from wrData[3]; the other bits of the control write have no effect.
- R7: The alarm flag is set on the clock edge at which an increment makes the time equal to {alarm seconds, alarm fraction}. The compare uses the alarm value held before that edge.
- R8: While the alarm seconds are all ones, no match sets the alarm flag.
- R9: The alarm flag stays set until a status write with wrData[4] = 1. Rewriting the alarm does not clear it, and a match on the same edge as a clear leaves it set.
- R10: A status write with wrData[1] = 1 and wrData[0] = 1 clears both nonValid and violation. A status write with only one of those two bits set changes neither.
- R11: violIn high on a clock edge sets violation, and it wins over a clear on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-power domain clock, one count per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| wrSecEn | input | 1 | Load seconds half of time |
| wrFracEn | input | 1 | Load fraction half of time |
| wrAlmSecEn | input | 1 | Load alarm seconds |
| wrAlmFracEn | input | 1 | Load alarm fraction |
| wrCtrlEn | input | 1 | Load control word (enable in bit 3) |
| wrStatEn | input | 1 | Status write-one-to-clear (bit 4 alarm, bits 1 and 0 valid/violation) |
| wrData | input | 32 | Shared write data |
| violIn | input | 1 | Synchronized violation event |
| secOut | output | 32 | Current seconds |
| fracOut | output | 15 | Current fraction |
| almSecOut | output | 32 | Alarm seconds |
| almFracOut | output | 15 | Alarm fraction |
| countEn | output | 1 | Count enable bit |
| alarmFlag | output | 1 | Sticky alarm flag |
| nonValid | output | 1 | Time not yet validated |
| violation | output | 1 | Security violation seen |

## Verification
Two situations are hardest to reach from the ports. One is an alarm hit landing on the exact edge of a clear write. The other is a match that only occurs across the fraction-to-seconds carry. For the carry case, the stimulus loads the time a few counts below a seconds boundary and places the alarm just past it. For the same-edge case, the bench watches its own model and raises the clear strobe in the cycle whose increment is due to reach the alarm. The frozen "never written" state is covered by enabling counting before any seconds write.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // Strobes from control to datapath, one cycle wide each
  typedef struct packed {
    logic loadSec;
    logic loadFrac;
    logic loadAlmSec;
    logic loadAlmFrac;
    logic step;
  } satStrobe_t;
endpackage

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrSecEn,
  input  logic       wrFracEn,
  input  logic       wrAlmSecEn,
  input  logic       wrAlmFracEn,
  input  logic       wrCtrlEn,
  input  logic       wrStatEn,
  input  logic       enBit,
  input  logic       afBit,
  input  logic       nvBit,
  input  logic       svBit,
  input  logic       violIn,
  input  logic       matchHit,
  output satStrobe_t strb,
  output logic       countEn,
  output logic       alarmFlag,
  output logic       nonValid,
  output logic       violation
);
  logic secSeen;
  logic clrAlarm;
  logic clrValid;

  assign clrAlarm = wrStatEn & afBit;
  assign clrValid = wrStatEn & nvBit & svBit;

  always_comb begin
    strb.loadSec     = wrSecEn;
    strb.loadFrac    = wrFracEn;
    strb.loadAlmSec  = wrAlmSecEn;
    strb.loadAlmFrac = wrAlmFracEn;
    // a time write in this cycle suppresses the increment
    strb.step        = countEn & secSeen & ~wrSecEn & ~wrFracEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countEn   <= 1'b0;
      secSeen   <= 1'b0;
      alarmFlag <= 1'b0;
      nonValid  <= 1'b1;
      violation <= 1'b0;
    end else begin
      if (wrCtrlEn) countEn <= enBit;
      if (wrSecEn)  secSeen <= 1'b1;
      if (matchHit)      alarmFlag <= 1'b1;
      else if (clrAlarm) alarmFlag <= 1'b0;
      if (clrValid) nonValid <= 1'b0;
      if (violIn)        violation <= 1'b1;
      else if (clrValid) violation <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int FRAC_W = 15,
  parameter int SEC_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  satStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [SEC_W-1:0]  secOut,
  output logic [FRAC_W-1:0] fracOut,
  output logic [SEC_W-1:0]  almSecOut,
  output logic [FRAC_W-1:0] almFracOut,
  output logic              matchHit
);
  localparam int TIME_W = FRAC_W + SEC_W;

  logic [TIME_W-1:0] timeNow;
  logic [TIME_W-1:0] timeNext;
  logic [TIME_W-1:0] almTime;
  logic              almOff;

  assign timeNow  = {secOut, fracOut};
  assign timeNext = timeNow + TIME_W'(1);
  assign almTime  = {almSecOut, almFracOut};
  assign almOff   = &almSecOut;
  assign matchHit = strb.step & ~almOff & (timeNext == almTime);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secOut  <= '0;
      fracOut <= '0;
    end else if (strb.loadSec || strb.loadFrac) begin
      if (strb.loadSec)  secOut  <= wrData[SEC_W-1:0];
      if (strb.loadFrac) fracOut <= wrData[FRAC_W-1:0];
    end else if (strb.step) begin
      {secOut, fracOut} <= timeNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almSecOut  <= '1;
      almFracOut <= '0;
    end else begin
      if (strb.loadAlmSec)  almSecOut  <= wrData[SEC_W-1:0];
      if (strb.loadAlmFrac) almFracOut <= wrData[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sat_pkg::*;
#(
  parameter int FRAC_W = 15,
  parameter int SEC_W  = 32,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 3,
  parameter int AF_BIT = 4,
  parameter int NV_BIT = 1,
  parameter int SV_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrSecEn,
  input  logic              wrFracEn,
  input  logic              wrAlmSecEn,
  input  logic              wrAlmFracEn,
  input  logic              wrCtrlEn,
  input  logic              wrStatEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              violIn,
  output logic [SEC_W-1:0]  secOut,
  output logic [FRAC_W-1:0] fracOut,
  output logic [SEC_W-1:0]  almSecOut,
  output logic [FRAC_W-1:0] almFracOut,
  output logic              countEn,
  output logic              alarmFlag,
  output logic              nonValid,
  output logic              violation
);
  satStrobe_t strb;
  logic       matchHit;
  logic       stepNow;

  assign stepNow = strb.step;

  sat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrSecEn    (wrSecEn),
    .wrFracEn   (wrFracEn),
    .wrAlmSecEn (wrAlmSecEn),
    .wrAlmFracEn(wrAlmFracEn),
    .wrCtrlEn   (wrCtrlEn),
    .wrStatEn   (wrStatEn),
    .enBit      (wrData[EN_BIT]),
    .afBit      (wrData[AF_BIT]),
    .nvBit      (wrData[NV_BIT]),
    .svBit      (wrData[SV_BIT]),
    .violIn     (violIn),
    .matchHit   (matchHit),
    .strb       (strb),
    .countEn    (countEn),
    .alarmFlag  (alarmFlag),
    .nonValid   (nonValid),
    .violation  (violation)
  );

  sat_datapath #(.FRAC_W(FRAC_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .secOut    (secOut),
    .fracOut   (fracOut),
    .almSecOut (almSecOut),
    .almFracOut(almFracOut),
    .matchHit  (matchHit)
  );
endmodule

// File: rtl/sat_checker.sv
module sat_checker #(
  parameter int FRAC_W = 15,
  parameter int SEC_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrSecEn,
  input logic              wrFracEn,
  input logic              wrCtrlEn,
  input logic              wrStatEn,
  input logic              enBit,
  input logic              afBit,
  input logic              nvBit,
  input logic              svBit,
  input logic              violIn,
  input logic              stepNow,
  input logic [SEC_W-1:0]  secOut,
  input logic [FRAC_W-1:0] fracOut,
  input logic [SEC_W-1:0]  almSecOut,
  input logic              countEn,
  input logic              alarmFlag,
  input logic              nonValid,
  input logic              violation
);
  localparam int TIME_W = FRAC_W + SEC_W;
  logic [TIME_W-1:0] timeCat;
  assign timeCat = {secOut, fracOut};

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> timeCat == $past(timeCat) + TIME_W'(1));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !wrSecEn && !wrFracEn) |=> $stable(timeCat));

  p_ctrl_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrlEn |=> countEn == $past(enBit));

  p_alarm_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((&almSecOut) && !alarmFlag) |=> !alarmFlag);

  p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !(wrStatEn && afBit)) |=> alarmFlag);

  p_valid_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatEn && nvBit && svBit && !violIn) |=> (!nonValid && !violation));

  p_viol_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    violIn |=> violation);
endmodule

bind sec_alarm_timer sat_checker #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrSecEn  (wrSecEn),
  .wrFracEn (wrFracEn),
  .wrCtrlEn (wrCtrlEn),
  .wrStatEn (wrStatEn),
  .enBit    (wrData[EN_BIT]),
  .afBit    (wrData[AF_BIT]),
  .nvBit    (wrData[NV_BIT]),
  .svBit    (wrData[SV_BIT]),
  .violIn   (violIn),
  .stepNow  (stepNow),
  .secOut   (secOut),
  .fracOut  (fracOut),
  .almSecOut(almSecOut),
  .countEn  (countEn),
  .alarmFlag(alarmFlag),
  .nonValid (nonValid),
  .violation(violation)
);

// File: tb/sec_alarm_timer_test.sv
module sec_alarm_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrSecEn = 0, wrFracEn = 0, wrAlmSecEn = 0, wrAlmFracEn = 0;
  logic        wrCtrlEn = 0, wrStatEn = 0, violIn = 0;
  logic [31:0] wrData = '0;
  logic [31:0] secOut, almSecOut;
  logic [14:0] fracOut, almFracOut;
  logic        countEn, alarmFlag, nonValid, violation;

  int nChk = 0;
  int nFail = 0;

  // behavioural reference state
  logic [46:0] mTime = '0;
  logic [31:0] mAlmSec = 32'hFFFF_FFFF;
  logic [14:0] mAlmFrac = '0;
  bit mEn = 0, mSeen = 0, mAf = 0, mNv = 1, mSv = 0;

  always #5 clk = ~clk;

  sec_alarm_timer uut (
    .clk(clk), .rstN(rstN),
    .wrSecEn(wrSecEn), .wrFracEn(wrFracEn), .wrAlmSecEn(wrAlmSecEn),
    .wrAlmFracEn(wrAlmFracEn), .wrCtrlEn(wrCtrlEn), .wrStatEn(wrStatEn),
    .wrData(wrData), .violIn(violIn),
    .secOut(secOut), .fracOut(fracOut), .almSecOut(almSecOut),
    .almFracOut(almFracOut), .countEn(countEn), .alarmFlag(alarmFlag),
    .nonValid(nonValid), .violation(violation)
  );

  // reference model: advances on each rising edge from the inputs in place
  always @(posedge clk) begin
    bit stepIt, hit, clrV;
    logic [46:0] nxt;
    if (!rstN) begin
      mTime = '0; mAlmSec = 32'hFFFF_FFFF; mAlmFrac = '0;
      mEn = 0; mSeen = 0; mAf = 0; mNv = 1; mSv = 0;
    end else begin
      stepIt = mEn && mSeen && !wrSecEn && !wrFracEn;
      nxt = mTime + 47'd1;
      hit = stepIt && (nxt == {mAlmSec, mAlmFrac}) && (mAlmSec != 32'hFFFF_FFFF);
      clrV = wrStatEn && wrData[1] && wrData[0];
      if (wrSecEn)  mTime[46:15] = wrData;
      if (wrFracEn) mTime[14:0]  = wrData[14:0];
      if (stepIt)   mTime = nxt;
      if (wrAlmSecEn)  mAlmSec  = wrData;
      if (wrAlmFracEn) mAlmFrac = wrData[14:0];
      if (wrCtrlEn) mEn = wrData[3];
      if (wrSecEn)  mSeen = 1;
      if (hit) mAf = 1; else if (wrStatEn && wrData[4]) mAf = 0;
      if (clrV) mNv = 0;
      if (violIn) mSv = 1; else if (clrV) mSv = 0;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (rstN) begin
    check("R2/R3/R4/R5 time", {17'd0, secOut, fracOut}, {17'd0, mTime});
    check("R5 alarm regs", {17'd0, almSecOut, almFracOut}, {17'd0, mAlmSec, mAlmFrac});
    check("R6 countEn", {63'd0, countEn}, {63'd0, mEn});
    check("R7/R8/R9 alarmFlag", {63'd0, alarmFlag}, {63'd0, mAf});
    check("R10 nonValid", {63'd0, nonValid}, {63'd0, mNv});
    check("R10/R11 violation", {63'd0, violation}, {63'd0, mSv});
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle write strobe; sel: 0 sec,1 frac,2 almSec,3 almFrac,4 ctrl,5 stat
  task automatic wr(input int sel, input logic [31:0] d);
    wrData = d;
    wrSecEn = (sel == 0); wrFracEn = (sel == 1); wrAlmSecEn = (sel == 2);
    wrAlmFracEn = (sel == 3); wrCtrlEn = (sel == 4); wrStatEn = (sel == 5);
    @(negedge clk);
    {wrSecEn, wrFracEn, wrAlmSecEn, wrAlmFracEn, wrCtrlEn, wrStatEn} = '0;
    wrData = '0;
  endtask

  // run, raising an alarm clear on the cycle whose increment reaches the alarm
  task automatic runClearOnHit(input int n);
    for (int i = 0; i < n; i++) begin
      if (mEn && mSeen && ((mTime + 47'd1) == {mAlmSec, mAlmFrac})) begin
        wrStatEn = 1; wrData = 32'h10;
      end
      @(negedge clk);
      wrStatEn = 0; wrData = '0;
    end
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values against constants
    check("R1 sec", {32'd0, secOut}, 64'd0);
    check("R1 almSec", {32'd0, almSecOut}, 64'hFFFF_FFFF);
    check("R1 flags", {60'd0, countEn, alarmFlag, nonValid, violation}, 64'b0010);

    // R4: enabled but seconds never written -> frozen
    wr(4, 32'h8);
    idle(20);
    // R4/R2: writing zero to seconds starts it
    wr(0, 32'd0);
    idle(25);
    // R6: other control bits ignored, enable bit clear -> stops
    wr(4, 32'hFFFF_FFF7);
    idle(10);
    wr(4, 32'h0000_0008);
    // R7/R3: alarm just past a seconds wrap from all ones
    wr(2, 32'd0);
    wr(3, 32'd3);
    wr(1, 32'd32760);
    wr(0, 32'hFFFF_FFFF);
    idle(20);
    // R9: rewriting alarm keeps flag; status bit 4 clears
    wr(2, 32'd100);
    idle(3);
    wr(5, 32'h0000_000F);
    idle(2);
    wr(5, 32'h10);
    idle(2);
    // R9: hit and clear on the same edge -> stays set
    wr(2, 32'd5);
    wr(3, 32'd10);
    wr(1, 32'd0);
    wr(0, 32'd5);
    runClearOnHit(20);
    wr(5, 32'h10);
    // R8: alarm seconds all ones disables the match
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'd40);
    wr(1, 32'd30);
    wr(0, 32'hFFFF_FFFF);
    idle(30);
    // R5: fraction write during counting
    wr(1, 32'hFFFF_7FF0);
    idle(5);
    // R10: only one clear bit -> nothing changes
    wr(5, 32'h2);
    wr(5, 32'h1);
    idle(2);
    wr(5, 32'h3);
    idle(2);
    // R11: violation set, and set wins over clear
    violIn = 1; @(negedge clk); violIn = 0;
    idle(2);
    violIn = 1; wrStatEn = 1; wrData = 32'h3; @(negedge clk);
    violIn = 0; wrStatEn = 0; wrData = '0;
    idle(2);
    wr(5, 32'h3);
    // R3: natural fraction carry over a full second
    wr(2, 32'd9);
    wr(3, 32'd2);
    wr(1, 32'd0);
    wr(0, 32'd8);
    idle(32800);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #(150000 * 10);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule